// File: doc/BRIEF.md
# Hashed Bit-Lock Unit

This unit keeps a small array of one-bit locks that several requesters share. A requester claims a lock by sending an acquire that carries a memory address. The unit folds that address into a lock index. In the same step it tests and sets the selected bit, and it reports whether the claim succeeded. A release that carries the same address clears the bit again. Software uses this to guard short critical sections on ordinary memory, such as an add or a compare-and-swap. No lock storage has to be allocated for this.

Any address maps onto the array, so unrelated addresses can share a lock. That costs some extra contention but never breaks mutual exclusion. The array can be cut down to a single bit. That bit then acts as one global lock and the address plays no part.

All requests presented in one cycle are served in that cycle. They are handled as if they ran one after another in ascending requester number. Every response is a registered one-cycle pulse.

Top module: `hashed_lock_unit`

## Requirements
- R1: An acquire whose lock bit is clear sets the bit and returns resp_ok=1 in the cycle after the request.
- R2: An acquire whose lock bit is already set returns resp_ok=0 and leaves every lock bit unchanged.
- R3: A release whose lock bit is set clears it and returns resp_ok=1, after which an acquire of that bit succeeds.
- R4: A release whose lock bit is clear changes no lock and returns resp_ok=0. It also sets rel_err, which then stays at 1 until reset.
- R5: With LOCK_LOG2=N>0, the lock index is addr[N+1:2] XOR addr[2N+1:N+2]. Address bits 1:0 and bits above 2N+1 do not affect the choice.
- R6: Requests in the same cycle take effect in ascending requester number. When two acquires hit the same free bit, the lower number gets resp_ok=1 and the higher gets 0. A lower-numbered release frees the bit for a higher-numbered acquire in the same cycle.
- R7: resp_valid[i] is 1 in exactly the cycle after req_valid[i] was 1, and resp_ok[i] is 0 whenever resp_valid[i] is 0.
- R8: Reset clears every lock bit, resp_valid, resp_ok and rel_err.
- R9: With LOCK_LOG2=0 there is one lock shared by every address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NUM_REQ | One request per requester this cycle |
| req_release | input | NUM_REQ | 1 = release, 0 = acquire |
| req_addr | input | NUM_REQ*ADDR_W | Address token; requester i uses bits [i*ADDR_W +: ADDR_W] |
| resp_valid | output | NUM_REQ | Response pulse, one cycle after the request |
| resp_ok | output | NUM_REQ | Acquire obtained / release found the lock held |
| rel_err | output | 1 | Sticky flag: a release hit a clear lock |

## Verification
The bench builds two copies of the unit. The first has three requesters and LOCK_LOG2=3, giving eight locks. That makes the XOR folding visible: addresses that differ only in ignored bits, and addresses that alias through the XOR, both meet on one lock. With three requesters, same-cycle acquire races and release-then-acquire ordering can be driven. The second copy has two requesters and LOCK_LOG2=0. It shows that widely different addresses contend for the one global lock.

// File: rtl/hlock_pkg.sv
package hlock_pkg;
  typedef enum logic {OP_ACQUIRE = 1'b0, OP_RELEASE = 1'b1} lock_op_e;

  // index width; a one-lock array still carries a one-bit index
  function automatic int idx_width(input int log2_locks);
    return (log2_locks == 0) ? 1 : log2_locks;
  endfunction
endpackage

// File: rtl/hlock_hash.sv
module hlock_hash #(
  parameter int ADDR_W    = 32,
  parameter int LOCK_LOG2 = 4,
  parameter int IDX_W     = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  generate
    if (LOCK_LOG2 == 0) begin : g_global
      assign idx = addr[0] & ~addr[0];
    end else begin : g_fold
      assign idx = addr[LOCK_LOG2+1:2] ^ addr[2*LOCK_LOG2+1:LOCK_LOG2+2];
    end
  endgenerate
endmodule

// File: rtl/hlock_resolve.sv
module hlock_resolve #(
  parameter int NUM_REQ = 4,
  parameter int NLOCKS  = 16,
  parameter int IDX_W   = 4
) (
  input  logic [NLOCKS-1:0]             held,
  input  logic [NUM_REQ-1:0]            valid,
  input  logic [NUM_REQ-1:0]            release_op,
  input  logic [NUM_REQ-1:0][IDX_W-1:0] idx,
  output logic [NLOCKS-1:0]             held_nxt,
  output logic [NUM_REQ-1:0]            ok,
  output logic                          bad_release
);
  logic [NLOCKS-1:0] cur;

  // serial semantics in ascending requester order within one cycle
  always_comb begin
    cur = held;
    ok  = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (valid[i]) begin
        if (release_op[i] == hlock_pkg::OP_RELEASE) begin
          ok[i]       = cur[idx[i]];
          cur[idx[i]] = 1'b0;
        end else begin
          ok[i]       = ~cur[idx[i]];
          cur[idx[i]] = 1'b1;
        end
      end
    end
    held_nxt    = cur;
    bad_release = |(valid & release_op & ~ok);
  end
endmodule

// File: rtl/hlock_store.sv
module hlock_store #(
  parameter int NLOCKS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLOCKS-1:0] held_nxt,
  output logic [NLOCKS-1:0] held
);
  always_ff @(posedge clk) begin
    if (rst) held <= '0;
    else     held <= held_nxt;
  end

  p_reset_clears_r8: assert property (@(posedge clk) rst |=> (held == '0));
endmodule

// File: rtl/hashed_lock_unit.sv
module hashed_lock_unit #(
  parameter int NUM_REQ   = 4,
  parameter int ADDR_W    = 32,
  parameter int LOCK_LOG2 = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_REQ-1:0]        req_valid,
  input  logic [NUM_REQ-1:0]        req_release,
  input  logic [NUM_REQ*ADDR_W-1:0] req_addr,
  output logic [NUM_REQ-1:0]        resp_valid,
  output logic [NUM_REQ-1:0]        resp_ok,
  output logic                      rel_err
);
  localparam int NLOCKS = 1 << LOCK_LOG2;
  localparam int IDX_W  = hlock_pkg::idx_width(LOCK_LOG2);

  logic [NUM_REQ-1:0][IDX_W-1:0] idx;
  logic [NLOCKS-1:0]             held, held_nxt;
  logic [NUM_REQ-1:0]            ok;
  logic                          bad_release;

  generate
    for (genvar g = 0; g < NUM_REQ; g++) begin : g_hash
      hlock_hash #(.ADDR_W(ADDR_W), .LOCK_LOG2(LOCK_LOG2), .IDX_W(IDX_W)) u_hash (
        .addr (req_addr[g*ADDR_W +: ADDR_W]),
        .idx  (idx[g])
      );
    end
  endgenerate

  hlock_resolve #(.NUM_REQ(NUM_REQ), .NLOCKS(NLOCKS), .IDX_W(IDX_W)) u_resolve (
    .held        (held),
    .valid       (req_valid),
    .release_op  (req_release),
    .idx         (idx),
    .held_nxt    (held_nxt),
    .ok          (ok),
    .bad_release (bad_release)
  );

  hlock_store #(.NLOCKS(NLOCKS)) u_store (
    .clk      (clk),
    .rst      (rst),
    .held_nxt (held_nxt),
    .held     (held)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= '0;
      resp_ok    <= '0;
      rel_err    <= 1'b0;
    end else begin
      resp_valid <= req_valid;
      resp_ok    <= ok;
      rel_err    <= rel_err | bad_release;
    end
  end

  // requester 0 is never overtaken, so its answer follows the stored bit alone
  p_acq_free_wins_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid[0] && !req_release[0] && !held[idx[0]]) |=> resp_ok[0]);
  p_acq_held_fails_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid[0] && !req_release[0] && held[idx[0]]) |=> (!resp_ok[0] && held == $past(held)));
  p_rel_clears_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid[0] && req_release[0] && held[idx[0]]) |=> resp_ok[0]);
  p_bad_rel_flags_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid[0] && req_release[0] && !held[idx[0]]) |=> (rel_err && !resp_ok[0]));
  p_err_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    rel_err |=> rel_err);

  generate
    for (genvar g = 0; g < NUM_REQ; g++) begin : g_resp_chk
      p_resp_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        req_valid[g] |=> resp_valid[g]);
      p_no_spurious_r7: assert property (@(posedge clk) disable iff (rst)
        !req_valid[g] |=> !resp_valid[g]);
      p_ok_needs_valid_r7: assert property (@(posedge clk) disable iff (rst)
        resp_ok[g] |-> resp_valid[g]);
    end
  endgenerate
endmodule

// File: tb/test_hashed_lock_unit.sv
module test_hashed_lock_unit;
  localparam int NR = 3;
  localparam int AW = 32;
  localparam int NV = 12;

  logic clk = 1'b0;
  logic rst;
  always #2 clk = ~clk;

  logic [NR-1:0]    v, r;
  logic [NR*AW-1:0] a;
  logic [NR-1:0]    rv, rok;
  logic             err;

  logic [1:0]    sv, sr;
  logic [2*AW-1:0] sa;
  logic [1:0]    srv, sok;
  logic          serr;

  hashed_lock_unit #(.NUM_REQ(NR), .ADDR_W(AW), .LOCK_LOG2(3)) i_hashed_lock_unit (
    .clk(clk), .rst(rst), .req_valid(v), .req_release(r), .req_addr(a),
    .resp_valid(rv), .resp_ok(rok), .rel_err(err));

  hashed_lock_unit #(.NUM_REQ(2), .ADDR_W(AW), .LOCK_LOG2(0)) i_hashed_lock_unit_single (
    .clk(clk), .rst(rst), .req_valid(sv), .req_release(sr), .req_addr(sa),
    .resp_valid(srv), .resp_ok(sok), .rel_err(serr));

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // fields: valid[45:43] release[42:40] a2[39:28] a1[27:16] a0[15:4] ok[3:1] err[0]
  localparam logic [45:0] VEC [NV] = '{
    {3'b001, 3'b000, 12'h000, 12'h000, 12'h100, 3'b001, 1'b0}, // R1 free lock 0
    {3'b010, 3'b000, 12'h000, 12'h000, 12'h000, 3'b000, 1'b0}, // R2 R5 bit 8 ignored
    {3'b100, 3'b000, 12'h004, 12'h000, 12'h000, 3'b100, 1'b0}, // R1 lock 1
    {3'b001, 3'b000, 12'h000, 12'h000, 12'h020, 3'b000, 1'b0}, // R5 xor alias to lock 1
    {3'b010, 3'b010, 12'h000, 12'h003, 12'h000, 3'b010, 1'b0}, // R3 R5 low bits ignored
    {3'b011, 3'b000, 12'h000, 12'h040, 12'h040, 3'b001, 1'b0}, // R6 race, lower id wins
    {3'b011, 3'b001, 12'h000, 12'h040, 12'h040, 3'b011, 1'b0}, // R6 release then acquire
    {3'b101, 3'b100, 12'h024, 12'h000, 12'h008, 3'b000, 1'b1}, // R4 bad release, R2 held
    {3'b100, 3'b000, 12'h024, 12'h000, 12'h000, 3'b100, 1'b1}, // R4 bad release left lock clear
    {3'b000, 3'b000, 12'h000, 12'h000, 12'h000, 3'b000, 1'b1}, // R7 idle, R4 sticky
    {3'b100, 3'b100, 12'h004, 12'h000, 12'h000, 3'b100, 1'b1}, // R3 release lock 1
    {3'b001, 3'b000, 12'h000, 12'h000, 12'h004, 3'b001, 1'b1}  // R3 reacquire lock 1
  };

  task automatic drive_main(input logic [2:0] vv, input logic [2:0] rr,
                            input logic [11:0] a0, input logic [11:0] a1, input logic [11:0] a2);
    v = vv; r = rr;
    a = {20'h0, a2, 20'h0, a1, 20'h0, a0};
  endtask

  task automatic single_step(input logic [1:0] vv, input logic [1:0] rr,
                             input logic [31:0] a0, input logic [31:0] a1, input logic [1:0] eok);
    @(negedge clk);
    sv = vv; sr = rr; sa = {a1, a0};
    @(posedge clk); #1;
    check("R9 single valid", {30'h0, srv}, {30'h0, vv});
    check("R9 single ok", {30'h0, sok}, {30'h0, eok});
  endtask

  initial begin
    rst = 1'b1;
    drive_main(3'b000, 3'b000, 12'h0, 12'h0, 12'h0);
    sv = '0; sr = '0; sa = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R8 reset resp_valid", {29'h0, rv}, 32'h0);
    check("R8 reset rel_err", {31'h0, err}, 32'h0);
    @(negedge clk); rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      drive_main(VEC[k][45:43], VEC[k][42:40], VEC[k][15:4], VEC[k][27:16], VEC[k][39:28]);
      @(posedge clk); #1;
      check("R7 resp_valid", {29'h0, rv}, {29'h0, VEC[k][45:43]});
      check("R1 R2 R3 R6 resp_ok", {29'h0, rok}, {29'h0, VEC[k][3:1]});
      check("R4 rel_err", {31'h0, err}, {31'h0, VEC[k][0]});
    end
    @(negedge clk); drive_main(3'b000, 3'b000, 12'h0, 12'h0, 12'h0);

    // R8: reset drops held locks and the error flag
    rst = 1'b1;
    @(posedge clk); #1;
    check("R8 rel_err cleared", {31'h0, err}, 32'h0);
    @(negedge clk); rst = 1'b0;
    drive_main(3'b001, 3'b000, 12'h004, 12'h0, 12'h0);
    @(posedge clk); #1;
    check("R8 lock freed by reset", {29'h0, rok}, 32'h1);
    @(negedge clk); drive_main(3'b000, 3'b000, 12'h0, 12'h0, 12'h0);

    // R9: one global lock, address ignored
    single_step(2'b01, 2'b00, 32'h0000_0000, 32'h0, 2'b01);
    single_step(2'b10, 2'b00, 32'h0, 32'hFFFF_FFF0, 2'b00);
    single_step(2'b01, 2'b01, 32'h0000_1234, 32'h0, 2'b01);
    single_step(2'b10, 2'b00, 32'h0, 32'h0000_5678, 2'b10);
    @(negedge clk); sv = '0;
    check("R9 single no error", {31'h0, serr}, 32'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule